// File: doc/BRIEF.md
# Serial Step-Attenuator Word Loader

This block programs a 6-bit digital step attenuator over a write-only three-wire link of serial clock, serial data and latch enable. A host presents an attenuation code together with a one-cycle start strobe. The block captures the code and drives it out one bit per serial clock period, least significant bit first. It then raises latch enable for a fixed minimum time and drops it, which is the moment the attenuator applies the new setting. Each code step is 0.5 dB, so the six bits carry weights of 0.5, 1, 2, 4, 8 and 16 dB.

The host sees `busy` while a word is in flight and a one-cycle `done` once the latch pulse has ended. The serial clock rate and the minimum latch time are derived from the system clock frequency by parameters, so the same block serves any rate up to the attenuator's 50 MHz limit. The default is 1 MHz.

Top module: `step_atten_loader`

## Requirements
- R1: After reset, `ser_clk`, `ser_data`, `ser_le`, `busy` and `done` are all low.
- R2: The captured code goes out least significant bit first: the value on `ser_data` at the k-th rising edge of `ser_clk` (k = 0..5) equals bit k of the code.
- R3: Exactly six rising edges of `ser_clk` occur per transfer, and `ser_clk` is low whenever the block is idle.
- R4: Each high phase and each low phase between rising edges of `ser_clk` lasts HALF_DIV = ceil(SYS_CLK_HZ / (2·SCLK_HZ)) system cycles. This is 125 cycles at the default 250 MHz and 1 MHz.
- R5: `ser_data` changes only while `ser_clk` is low, and it is stable for at least HALF_DIV cycles before each rising edge.
- R6: `ser_le` is low while bits are being shifted and never high together with `ser_clk`. After the sixth bit it is high for exactly floor(SYS_CLK_HZ·1 µs)+1 cycles, which is 251 at default, so the pulse always exceeds 1 µs.
- R7: `done` is high for exactly one cycle, the first cycle in which `ser_le` is low again. `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after.
- R8: A start strobe that arrives while `busy` is high, including during the latch pulse and the `done` cycle, is ignored. It neither alters the word being sent nor begins another transfer.
- R9: The code is captured when the start is accepted. Later changes on `code` do not affect the word sent.
- R10: The two extreme codes, 6'b000000 (0 dB) and 6'b111111 (31.5 dB), are sent correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to load `code` |
| code | input | CODE_W | Attenuation code, 0.5 dB per LSB |
| ser_clk | output | 1 | Serial clock to the attenuator, idles low |
| ser_data | output | 1 | Serial data, LSB first |
| ser_le | output | 1 | Latch enable; the setting applies on its falling edge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after latch enable falls |

## Verification
The loader is driven with the all-zero and all-one codes, with single-bit codes at each end of the word, with an alternating pattern, and with seeded random codes. A word sent in reversed bit order or shifted by one position differs from the expected value in at least one of these cases. Some transfers include a second start during shifting, during the latch pulse and in the `done` cycle, each with the inverted code. The `code` input is also scrambled right after acceptance. Together these separate a design that holds its captured word from one that re-samples the input or restarts. A monitor measures every clock phase, every data setup window and the latch pulse length, so an off-by-one in either divider is caught.

// File: rtl/atten_pkg.sv
// Shared types for the step-attenuator word loader.
// Assumes: nothing beyond a single clock domain.
package atten_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_LATCH = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_t;
endpackage

// File: rtl/atten_tick_gen.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every HALF_DIV enabled cycles; clr restarts the count.
// Assumes HALF_DIV >= 1.
module atten_tick_gen #(
    parameter int HALF_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count enabled cycles, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/atten_shift_reg.sv
// Holding and shift register for the attenuation word.
// Loads the code on load, moves it right one place on shift, LSB presented on dout.
// Assumes load and shift are never high together.
module atten_shift_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         dout
);
    logic [W-1:0] sh_q;

    assign dout = sh_q[0];

    // Capture the word on load, drain it LSB first on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end
endmodule

// File: rtl/atten_latch_timer.sv
// Latch-pulse timer: while run is high, asserts expired in the LATCH_CYC-th cycle.
// Assumes run is held high until expired is seen; dropping run resets it.
module atten_latch_timer #(
    parameter int LATCH_CYC = 251
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LATCH_CYC > 1) ? $clog2(LATCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LATCH_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    // Count cycles spent with the latch pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/step_atten_loader.sv
// Serial word loader for a digital step attenuator.
// Accepts a code on start when idle, shifts it LSB first on a divided serial
// clock (idle low, data moved on the falling edge), then holds latch enable
// high for a time that strictly exceeds LATCH_MIN_NS and pulses done.
// Assumes SYS_CLK_HZ >= 2*SCLK_HZ and SCLK_HZ <= 50 MHz.
module step_atten_loader #(
    parameter int CODE_W       = 6,
    parameter int SYS_CLK_HZ   = 250_000_000,
    parameter int SCLK_HZ      = 1_000_000,
    parameter int LATCH_MIN_NS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              busy,
    output logic              done
);
    import atten_pkg::*;

    localparam int HALF_DIV_RAW = (SYS_CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
    localparam int HALF_DIV     = (HALF_DIV_RAW < 1) ? 1 : HALF_DIV_RAW;
    localparam longint LATCH_L  = (longint'(SYS_CLK_HZ) * longint'(LATCH_MIN_NS))
                                  / 64'sd1_000_000_000 + 64'sd1;
    localparam int LATCH_CYC    = int'(LATCH_L);
    localparam int BW           = $clog2(CODE_W + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(CODE_W - 1);

    ld_state_t     state_q;
    logic [BW-1:0] bit_q;
    logic          clk_q;
    logic          le_q;
    logic          tick;
    logic          lat_exp;
    logic          accept;
    logic          shift_now;

    assign accept    = start && (state_q == LD_IDLE);
    assign shift_now = (state_q == LD_SHIFT) && tick && clk_q;

    atten_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (state_q == LD_SHIFT),
        .tick  (tick)
    );

    atten_shift_reg #(.W(CODE_W)) shreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (shift_now),
        .din   (code),
        .dout  (ser_data)
    );

    atten_latch_timer #(.LATCH_CYC(LATCH_CYC)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == LD_LATCH),
        .expired (lat_exp)
    );

    // Sequence idle -> shift -> latch -> done and drive serial clock and latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            bit_q   <= '0;
            clk_q   <= 1'b0;
            le_q    <= 1'b0;
        end else begin
            unique case (state_q)
                LD_IDLE: begin
                    if (start) begin
                        state_q <= LD_SHIFT;
                        bit_q   <= '0;
                        clk_q   <= 1'b0;
                    end
                end
                LD_SHIFT: begin
                    if (tick) begin
                        if (!clk_q) begin
                            clk_q <= 1'b1;
                        end else begin
                            clk_q <= 1'b0;
                            bit_q <= bit_q + 1'b1;
                            if (bit_q == LAST_BIT) begin
                                state_q <= LD_LATCH;
                                le_q    <= 1'b1;
                            end
                        end
                    end
                end
                LD_LATCH: begin
                    if (lat_exp) begin
                        le_q    <= 1'b0;
                        state_q <= LD_DONE;
                    end
                end
                LD_DONE: begin
                    state_q <= LD_IDLE;
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign ser_clk = clk_q;
    assign ser_le  = le_q;
    assign busy    = (state_q != LD_IDLE);
    assign done    = (state_q == LD_DONE);
endmodule

// File: rtl/step_atten_loader_chk.sv
// Protocol checker for the step-attenuator loader, bound to the top module.
// Assumes LATCH_CYC matches the loader's derived latch length.
module step_atten_loader_chk #(
    parameter int LATCH_CYC = 251
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le,
    input logic busy,
    input logic done
);
    localparam int CW = $clog2(LATCH_CYC + 2);

    logic [CW-1:0] le_len_q;

    // Measure how long latch enable has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_le) begin
            le_len_q <= '0;
        end else if (le_len_q != CW'(LATCH_CYC + 1)) begin
            le_len_q <= le_len_q + 1'b1;
        end
    end

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_le));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R5
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    // R6
    le_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_le && ser_clk));

    // R6
    le_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_le) |-> ($past(le_len_q) == CW'(LATCH_CYC - 1)));

    // R7
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(ser_le));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
endmodule

bind step_atten_loader step_atten_loader_chk #(.LATCH_CYC(LATCH_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_le   (ser_le),
    .busy     (busy),
    .done     (done)
);

// File: tb/step_atten_loader_tb.sv
module step_atten_loader_tb_top;
    localparam int W    = 6;
    localparam int SYS  = 250_000_000;
    localparam int SCLK = 1_000_000;
    localparam int HALF = (SYS + 2 * SCLK - 1) / (2 * SCLK);
    localparam int LATCH = (SYS / 1000) * 1000 / 1_000_000 + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] code = '0;
    logic         ser_clk, ser_data, ser_le, busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    step_atten_loader #(.CODE_W(W), .SYS_CLK_HZ(SYS), .SCLK_HZ(SCLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_word(input logic [W-1:0] c);
        return int'(c);
    endfunction

    // Monitor of the serial link, sampled on the falling system edge.
    logic         p_clk = 0, p_data = 0, p_le = 0, p_done = 0;
    int           clk_run = 0, data_run = 0, le_run = 0, nbits = 0;
    logic [W-1:0] word = '0, got_word = '0;
    int           got_bits = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk != p_clk) begin
                if (p_clk) chk("R4 high phase", clk_run, HALF);
                else begin
                    if (nbits > 0) chk("R4 low phase", clk_run, HALF);
                    chk("R5 setup ok", int'(data_run >= HALF), 1);
                    chk("R6 le low while shifting", int'(ser_le), 0);
                    if (nbits < W) word[nbits] = ser_data;
                    nbits++;
                end
                clk_run = 1;
            end else clk_run++;
            if (ser_data != p_data) begin
                if (ser_clk && p_clk) chk("R5 data moved while clk high", 1, 0);
                data_run = 1;
            end else data_run++;
            if (ser_le && !p_le) begin
                chk("R3 six edges before latch", nbits, W);
                got_word = word;
                got_bits = nbits;
                le_run = 1;
            end else if (ser_le) le_run++;
            if (!ser_le && p_le) begin
                chk("R6 latch length", le_run, LATCH);
                chk("R7 done at latch fall", int'(done), 1);
                nbits = 0;
                word = '0;
            end
            if (p_done) chk("R7 done one cycle", int'(done), 0);
            p_clk = ser_clk; p_data = ser_data; p_le = ser_le; p_done = done;
        end
    end

    // mode: 0 none, 1 extra start at cycle inj_at, 2 extra start in done cycle
    task automatic run_txn(input logic [W-1:0] c, input int mode, input int inj_at,
                           input string tag);
        int n;
        @(negedge clk);
        code = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        code = W'($urandom);                      // R9 scramble after capture
        chk("R7 busy after accept", int'(busy), 1);
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
            if (mode == 1 && n == inj_at) begin start = 1'b1; code = ~c; end
            else start = 1'b0;
        end
        chk({tag, " done seen"}, int'(done), 1);
        if (mode == 2) begin start = 1'b1; code = ~c; end
        chk({tag, " R2 R9 word LSB first"}, int'(got_word), expect_word(c));
        chk({tag, " R3 bit count"}, got_bits, W);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R7 R8 busy low after done"}, int'(busy), 0);
        repeat (3) @(negedge clk);
        chk({tag, " R8 no extra transfer"}, int'(busy) + int'(ser_clk) + int'(ser_le), 0);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0A77_E45D));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 ser_clk", int'(ser_clk), 0);
        chk("R1 ser_data", int'(ser_data), 0);
        chk("R1 ser_le", int'(ser_le), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_txn(6'b000000, 0, 0, "R10 zero");
        run_txn(6'b111111, 0, 0, "R10 ones");
        run_txn(6'b000001, 0, 0, "lsb only");
        run_txn(6'b100000, 0, 0, "msb only");
        run_txn(6'b010101, 1, 300, "R8 start while shifting");
        run_txn(6'b101100, 1, 1600, "R8 start while latching");
        run_txn(6'b011010, 2, 0, "R8 start in done cycle");
        for (int i = 0; i < 28; i++) begin
            run_txn(W'($urandom), int'($urandom_range(0, 2)),
                    int'($urandom_range(1, 1700)), "random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule